// File: doc/BRIEF.md
# Fault-Tolerant Three-Phase Sine Reference Generator

This block produces the three signed sine references that feed the PWM comparators of a three-phase, multi-level, neutral-clamped inverter. All three references come from one shared phase accumulator, which advances by a phase-increment word on every clock. Each phase adds a fixed angular offset to the accumulator and reads a quarter-wave sine table. The table output is then scaled by the requested amplitude, after that amplitude has been clamped.

A single device that fails in one leg can be open or shorted, and it can be a switch or a diode. Either way, that leg can then only be held at the DC-link midpoint. When fault detection reports the failed phase through a strobe and a phase index, the block waits for a programmable number of clocks. It then latches fault mode:
- The failed phase's reference goes to zero and its force-neutral flag is raised.
- The two healthy references are moved to ±150° around the failed phase's angle.
- The amplitude is capped at 1/√3 of full scale, so that the line-to-line voltages stay balanced.

Fault mode clears only on reset.

Top module: `tri_ref_gen`

## Requirements
- R1: While reset is asserted, all three references read 0, `neutral_force` reads 3'b000 and `fault_mode` reads 0.
- R2: In normal mode, each clock the block registers `ref_x = floor(T(i) * A / 32768)`, where `A` is the effective amplitude. The terms are:
  - The 16-bit accumulator starts at 0 after reset and adds `phase_inc` on every clock.
  - Phase a uses the accumulator's value before that clock. Phase b uses it minus 21845. Phase c uses it plus 21845. All sums are taken modulo 65536, which is one full cycle.
  - `i` is the top 8 bits of the phase sum.
  - `T(i)` is `32767*sin((i+0.5)*2π/256)`, rounded.
  - Results beyond ±32767 saturate.
- R3: In normal mode the effective amplitude is `min(amp_req, 32768)`, where 32768 is unity.
- R4: An accepted strobe is sampled at clock edge n with delay D on `reconf_delay`. The references, `neutral_force` and `fault_mode` switch to fault behaviour at edge n+D+2, and they keep their normal behaviour before that edge.
- R5: In fault mode the failed phase's reference is 0, and `neutral_force` has only bit k set, where k is that phase. Index 0 is phase a, 1 is b and 2 is c.
- R6: In fault mode, let θf be the failed phase's normal angle. Phase (k+1) mod 3 uses θf−27307 and phase (k+2) mod 3 uses θf+27307, where 27307 is 150°. Otherwise the formula of R2 applies.
- R7: In fault mode the effective amplitude is `min(amp_req, 18918)`, which is 0.57735 of unity.
- R8: Fault mode and the failed-phase index latch. Strobes arriving while a fault is pending or latched are ignored, and only reset clears the latch.
- R9: A strobe whose `fault_phase` is 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_inc | input | 16 | Accumulator step per clock |
| amp_req | input | 16 | Requested amplitude, unsigned, 32768 = unity |
| fault_stb | input | 1 | One-cycle fault report |
| fault_phase | input | 2 | Failed phase: 0 a, 1 b, 2 c, 3 invalid |
| reconf_delay | input | 24 | Clocks to wait before reconfiguring |
| ref_a | output | 16 | Signed reference, phase a |
| ref_b | output | 16 | Signed reference, phase b |
| ref_c | output | 16 | Signed reference, phase c |
| neutral_force | output | 3 | Per-phase clamp-to-neutral flag, bit 0 = a |
| fault_mode | output | 1 | Reconfigured operation active |

## Verification
The assertions assume that fault detection reports at most one failed phase per reset period. They also assume that `amp_req` is a magnitude that may exceed unity, so the amplitude clamp must keep every fault-mode reference within the 1/√3 bound. The stimulus respects these assumptions:
- The only additional strobes it sends are duplicate or invalid reports, which the block must ignore.
- Before each new fault case it applies reset.
- It holds `phase_inc`, `amp_req` and `reconf_delay` stable across every strobe.

// File: rtl/tri_ref_pkg.sv
package tri_ref_pkg;

  localparam int NPH = 3;

  // Entry k of a quarter-wave table of depth entries, scaled to full:
  // round(full * sin((k + 0.5) * pi / (2 * depth))), Taylor series in Q30.
  function automatic int quarter_sine(input int k, input int depth, input int full);
    longint x;
    longint t;
    longint s;
    x = (64'sd3373259426 * longint'(2 * k + 1)) / longint'(4 * depth);
    t = x;
    s = x;
    for (int n = 1; n <= 5; n++) begin
      t = (t * x) >>> 30;
      t = (t * x) >>> 30;
      t = -t / longint'((2 * n) * (2 * n + 1));
      s = s + t;
    end
    return int'((s * longint'(full) + (64'sd1 <<< 29)) >>> 30);
  endfunction

endpackage

// File: rtl/tri_ref_rom.sv
module tri_ref_rom #(
  parameter int TBL_AW = 6,
  parameter int DW     = 16
) (
  input  logic [TBL_AW+1:0]     idx,
  output logic signed [DW-1:0]  val
);
  localparam int DEPTH = 1 << TBL_AW;
  localparam int FULL  = (1 << (DW - 1)) - 1;

  logic [DW-1:0]         rom [DEPTH];
  logic [TBL_AW-1:0]     addr;
  logic signed [DW-1:0]  mag;

  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign rom[k] = DW'(tri_ref_pkg::quarter_sine(k, DEPTH, FULL));
  end

  // Quadrants 1 and 3 read the table mirrored; quadrants 2 and 3 negate.
  always_comb begin
    addr = idx[TBL_AW] ? ~idx[TBL_AW-1:0] : idx[TBL_AW-1:0];
    mag  = signed'(rom[addr]);
    val  = idx[TBL_AW+1] ? -mag : mag;
  end
endmodule

// File: rtl/tri_ref_lane.sv
module tri_ref_lane #(
  parameter int TBL_AW = 6,
  parameter int DW     = 16,
  parameter int AW     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TBL_AW+1:0]    idx,
  input  logic [AW-1:0]        amp,
  input  logic                 zero_i,
  output logic signed [DW-1:0] ref_o
);
  localparam int PW = DW + AW + 1;
  localparam logic signed [PW-1:0] PMAX = PW'((1 << (DW - 1)) - 1);

  logic signed [DW-1:0] tbl_val;

  tri_ref_rom #(.TBL_AW(TBL_AW), .DW(DW)) i_rom (
    .idx (idx),
    .val (tbl_val)
  );

  // Amplitude is unsigned Q1.(AW-1); product is floored back and saturated.
  function automatic logic signed [DW-1:0] scale_sat(input logic signed [DW-1:0] s,
                                                     input logic [AW-1:0] a);
    logic signed [PW-1:0] p;
    p = PW'(s) * PW'(signed'({1'b0, a}));
    p = p >>> (AW - 1);
    if (p > PMAX)       return DW'(PMAX);
    else if (p < -PMAX) return DW'(-PMAX);
    else                return p[DW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_o <= '0;
    else        ref_o <= zero_i ? '0 : scale_sat(tbl_val, amp);
  end
endmodule

// File: rtl/tri_ref_fault_seq.sv
module tri_ref_fault_seq #(
  parameter int DLY_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  logic [1:0]       phase_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             active_o,
  output logic [1:0]       fidx_o
);
  logic             pend_q;
  logic [DLY_W-1:0] cnt_q;
  logic             accept;
  logic             wait_done;

  assign accept    = stb_i && (phase_i != 2'd3) && !pend_q && !active_o;
  assign wait_done = pend_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      cnt_q    <= '0;
      active_o <= 1'b0;
      fidx_o   <= 2'd0;
    end else if (accept) begin
      pend_q <= 1'b1;
      cnt_q  <= delay_i;
      fidx_o <= phase_i;
    end else if (wait_done) begin
      pend_q   <= 1'b0;
      active_o <= 1'b1;
    end else if (pend_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |=> (active_o && $stable(fidx_o)));
  assert_pending_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !wait_done) |=> (pend_q && $stable(fidx_o)));
  assert_invalid_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && phase_i == 2'd3 && !pend_q && !active_o) |=> (!pend_q && !active_o));
  assert_entry_after_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(pend_q));
  assert_accept_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pend_q && !active_o));
endmodule

// File: rtl/tri_ref_gen.sv
module tri_ref_gen #(
  parameter int PH_W      = 16,
  parameter int TBL_AW    = 6,
  parameter int DW        = 16,
  parameter int AW        = 16,
  parameter int DLY_W     = 24,
  parameter int FAULT_CAP = 18918
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PH_W-1:0]      phase_inc,
  input  logic [AW-1:0]        amp_req,
  input  logic                 fault_stb,
  input  logic [1:0]           fault_phase,
  input  logic [DLY_W-1:0]     reconf_delay,
  output logic signed [DW-1:0] ref_a,
  output logic signed [DW-1:0] ref_b,
  output logic signed [DW-1:0] ref_c,
  output logic [2:0]           neutral_force,
  output logic                 fault_mode
);
  import tri_ref_pkg::*;

  localparam int AMP_ONE = 1 << (AW - 1);
  localparam logic [PH_W-1:0] OFF120 = PH_W'(((1 << PH_W) + 1) / 3);
  localparam logic [PH_W-1:0] OFF150 = PH_W'((5 * (1 << PH_W) + 6) / 12);

  logic [PH_W-1:0]      acc_q;
  logic                 active;
  logic [1:0]           fidx;
  logic [AW-1:0]        amp_cap;
  logic [AW-1:0]        amp_eff;
  logic signed [DW-1:0] ref_w [NPH];

  tri_ref_fault_seq #(.DLY_W(DLY_W)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_i    (fault_stb),
    .phase_i  (fault_phase),
    .delay_i  (reconf_delay),
    .active_o (active),
    .fidx_o   (fidx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_q + phase_inc;
  end

  always_comb begin
    amp_cap = active ? AW'(FAULT_CAP) : AW'(AMP_ONE);
    amp_eff = (amp_req > amp_cap) ? amp_cap : amp_req;
  end

  function automatic logic [PH_W-1:0] base_off(input int p);
    if (p == 1)      return -OFF120;
    else if (p == 2) return OFF120;
    else             return '0;
  endfunction

  // Table index for lane p: normal 0/-120/+120, fault +-150 around the failed phase.
  function automatic logic [TBL_AW+1:0] lane_idx(input int p, input logic [PH_W-1:0] acc,
                                                 input logic flt, input logic [1:0] f);
    logic [PH_W-1:0] ang;
    int fi;
    fi = int'(f);
    if (!flt)                  ang = acc + base_off(p);
    else if (p == (fi + 1) % 3) ang = acc + base_off(fi) - OFF150;
    else                       ang = acc + base_off(fi) + OFF150;
    return ang[PH_W-1 -: TBL_AW+2];
  endfunction

  for (genvar g = 0; g < NPH; g++) begin : g_lane
    logic [TBL_AW+1:0] idx;
    logic              zero;
    assign idx  = lane_idx(g, acc_q, active, fidx);
    assign zero = active && (fidx == 2'(g));

    tri_ref_lane #(.TBL_AW(TBL_AW), .DW(DW), .AW(AW)) i_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx    (idx),
      .amp    (amp_eff),
      .zero_i (zero),
      .ref_o  (ref_w[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) neutral_force[g] <= 1'b0;
      else        neutral_force[g] <= zero;
    end

    assert_zero_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
      neutral_force[g] |-> (ref_w[g] == '0));
    assert_fault_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_mode |-> (int'(ref_w[g]) <= FAULT_CAP && int'(ref_w[g]) >= -FAULT_CAP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_mode <= 1'b0;
    else        fault_mode <= active;
  end

  assign ref_a = ref_w[0];
  assign ref_b = ref_w[1];
  assign ref_c = ref_w[2];

  assert_single_neutral_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_mode |-> ($countones(neutral_force) == 1));
  assert_no_neutral_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_mode |-> (neutral_force == 3'b000));
  assert_mode_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_mode |=> (fault_mode && $stable(neutral_force)));
endmodule

// File: tb/test_tri_ref_gen.sv
module test_tri_ref_gen;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       phase_inc = '0;
  logic [15:0]       amp_req = '0;
  logic              fault_stb = 1'b0;
  logic [1:0]        fault_phase = '0;
  logic [23:0]       reconf_delay = '0;
  logic signed [15:0] ref_a, ref_b, ref_c;
  logic [2:0]        neutral_force;
  logic              fault_mode;

  always #4 clk = ~clk;

  tri_ref_gen i_tri_ref_gen (
    .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .amp_req(amp_req),
    .fault_stb(fault_stb), .fault_phase(fault_phase), .reconf_delay(reconf_delay),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .neutral_force(neutral_force), .fault_mode(fault_mode)
  );

  int errors = 0;
  int checks = 0;
  bit chk_en = 0;
  string norm_tag = "R2";
  string fault_tag = "R6";

  // Behavioural model state
  int acc_m, cyc, sw_cyc, f_m;
  bit armed;
  real exp_r [3];
  int exp_n, exp_mode;
  int base [3] = '{0, -21845, 21845};

  function automatic real ideal(input int ang, input int amp);
    int i;
    i = (ang & 65535) >> 8;
    return (amp / 32768.0) * 32767.0 * $sin((i + 0.5) * 2.0 * 3.14159265358979 / 256.0);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int expv, input int tol);
    checks++;
    if (act > expv + tol || act < expv - tol) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      acc_m = 0; cyc = 0; armed = 0; sw_cyc = 0; f_m = 0;
      exp_n = 0; exp_mode = 0;
      for (int p = 0; p < 3; p++) exp_r[p] = 0.0;
    end else begin
      bit md;
      int cap, a_eff, off;
      md = armed && (cyc >= sw_cyc);
      cap = md ? 18918 : 32768;
      a_eff = (int'(amp_req) > cap) ? cap : int'(amp_req);
      for (int p = 0; p < 3; p++) begin
        if (md && p == f_m) exp_r[p] = 0.0;
        else begin
          if (!md) off = base[p];
          else if (p == (f_m + 1) % 3) off = base[f_m] - 27307;
          else off = base[f_m] + 27307;
          exp_r[p] = ideal(acc_m + off, a_eff);
        end
      end
      exp_n = md ? (1 << f_m) : 0;
      exp_mode = md;
      if (fault_stb && fault_phase != 2'd3 && !armed) begin
        armed = 1;
        f_m = int'(fault_phase);
        sw_cyc = cyc + int'(reconf_delay) + 2;
      end
      acc_m = (acc_m + int'(phase_inc)) & 65535;
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      int act [3];
      act[0] = int'(ref_a); act[1] = int'(ref_b); act[2] = int'(ref_c);
      for (int p = 0; p < 3; p++) begin
        string t;
        t = exp_mode ? ((p == f_m) ? "R5" : fault_tag) : norm_tag;
        chk(t, $sformatf("ref[%0d] cycle %0d", p, cyc), act[p], $rtoi(exp_r[p] + (exp_r[p] < 0 ? -0.5 : 0.5)), 2);
      end
      chk("R5", "neutral_force", int'(neutral_force), exp_n, 0);
      chk("R4", "fault_mode", int'(fault_mode), exp_mode, 0);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [1:0] ph, input int dly);
    reconf_delay = 24'(dly);
    fault_phase = ph;
    fault_stb = 1'b1;
    @(negedge clk);
    fault_stb = 1'b0;
  endtask

  task automatic do_reset;
    chk_en = 0;
    rst_n = 1'b0;
    run(3);
    chk("R8", "fault_mode cleared by reset", int'(fault_mode), 0, 0);
    chk("R8", "neutral cleared by reset", int'(neutral_force), 0, 0);
    rst_n = 1'b1;
    chk_en = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    run(3);
    chk("R1", "ref_a in reset", int'(ref_a), 0, 0);
    chk("R1", "ref_b in reset", int'(ref_b), 0, 0);
    chk("R1", "ref_c in reset", int'(ref_c), 0, 0);
    chk("R1", "neutral in reset", int'(neutral_force), 0, 0);
    chk("R1", "fault_mode in reset", int'(fault_mode), 0, 0);
    rst_n = 1'b1;
    chk_en = 1;

    // R2: normal references, slow step
    phase_inc = 16'd300; amp_req = 16'd20000; norm_tag = "R2";
    run(300);
    // R3: requested amplitude above unity is clamped
    phase_inc = 16'd1777; amp_req = 16'd50000; norm_tag = "R3";
    run(100);
    // R9: invalid phase index is ignored
    strobe(2'd3, 0);
    run(10);
    chk("R9", "fault_mode after index 3", int'(fault_mode), 0, 0);
    chk("R9", "neutral after index 3", int'(neutral_force), 0, 0);
    // R4/R6/R7: fault on b after 20 clocks, amplitude above the cap
    fault_tag = "R7";
    strobe(2'd1, 20);
    run(100);
    // R8: later report on a is ignored
    strobe(2'd0, 0);
    run(10);
    chk("R8", "neutral after second strobe", int'(neutral_force), 3'b010, 0);
    chk("R8", "fault_mode after second strobe", int'(fault_mode), 1, 0);

    // R6: fault on c, no delay, amplitude below the cap
    do_reset();
    phase_inc = 16'd500; amp_req = 16'd10000; fault_tag = "R6"; norm_tag = "R2";
    run(5);
    strobe(2'd2, 0);
    run(200);

    // R7: fault on a after 5 clocks, amplitude between cap and unity
    do_reset();
    phase_inc = 16'd911; amp_req = 16'd30000; fault_tag = "R7";
    run(7);
    strobe(2'd0, 5);
    run(150);

    chk_en = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule